// File: doc/BRIEF.md
# Shared Destination Lookup Orchestrator

This block lets several parallel ingress pipelines share one destination address table, so that an address learned through any pipeline is visible to all. When a pipeline finishes parsing a packet header, it hands the block a destination MAC address. The block holds the request in a one-deep slot for that pipeline and grants one slot per cycle in round-robin order. The granted address goes into a two-stage table pipeline together with the requester's ID. Each reply, a per-port forwarding mask, returns to the requesting pipeline on a one-hot valid vector. A new issue can start every cycle while earlier ones are still in flight. Replies cannot be back-pressured, so no pipeline is ever stalled by the return path.

The block also takes learning writes, each an address and the port it was seen on. A write is accepted only in cycles with no lookup pending, so lookups always have priority. The write is committed only when the frame that supplied it carried a good checksum. An address already present is updated in place. A new address takes a free entry. When the table is full, the entries are overwritten in rotating order.

Back-pressure rules: a pipeline may present `req_valid` only while its `req_ready` is high. With minimum-size frames a pipeline requests at most once every eight cycles, so a correct pipeline never sees `req_ready` low when it needs it. A request presented while the slot is full is dropped and reported. The learning port is a normal valid/ready handshake: a write transfers on the cycle where `lrn_valid` and `lrn_ready` are both high.

Top module: `lkp_orchestrator`

## Requirements
- R1: After reset, every `req_ready` bit and `lrn_ready` are 1, and `rsp_valid` and `req_overrun` are all 0.
- R2: A request is captured on a cycle with `req_valid[i]` and `req_ready[i]` both high. `req_ready[i]` is 0 in the next cycle. It is back to 1 one cycle after the request is granted.
- R3: An uncontended request captured in cycle t produces its reply in cycle t+3: one cycle to grant and issue, then two table stages. `req_ready[i]` rising is always followed one cycle later by `rsp_valid[i]`.
- R4: Pending requests are granted one per cycle, starting with the pipeline after the most recently granted one and wrapping around. Pipeline 0 is first after reset. No request waits more than P-1 cycles behind others.
- R5: A reply asserts only the `rsp_valid` bit of the pipeline that asked, and at most one `rsp_valid` bit is set in any cycle.
- R6: On a miss, `rsp_hit` is 0 and `rsp_mask` has every bit set except the bit of the requester's own port. Pipeline i serves port i.
- R7: On a hit, `rsp_hit` is 1 and `rsp_mask` is one-hot at the learned port. If the learned port is the requester's own port, the mask is all zero.
- R8: `lrn_ready` is 0 in any cycle where any request slot holds a pending request.
- R9: A learning write accepted with `lrn_fcs_ok` = 0 leaves the table unchanged, so a later lookup of that address still misses.
- R10: A learning write for an address already in the table replaces its port.
- R11: A `req_valid[i]` while `req_ready[i]` is 0 raises `req_overrun[i]` for one cycle, in the next cycle. The held request keeps its original address.
- R12: A learning write of a new address into a full table overwrites entries in rotating order, starting at entry 0 after reset. Entries are filled in index order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | P | Lookup request per pipeline |
| req_ready | output | P | Request slot of the pipeline is empty |
| req_mac | input | P*MAC_W | Destination address per pipeline, pipeline i at bits [i*MAC_W +: MAC_W] |
| req_overrun | output | P | One-cycle pulse: request offered while the slot was full |
| rsp_valid | output | P | One-hot reply strobe, bit i for pipeline i |
| rsp_hit | output | 1 | Reply found the address in the table |
| rsp_mask | output | P | Forwarding port mask of the reply |
| lrn_valid | input | 1 | Learning write offered |
| lrn_ready | output | 1 | Learning write can be taken this cycle |
| lrn_fcs_ok | input | 1 | Frame that supplied the write passed its checksum |
| lrn_mac | input | MAC_W | Source address to learn |
| lrn_port | input | $clog2(P) | Port the address was seen on |

## Verification
A wrong arbiter pointer shows up as replies in the wrong order on `rsp_valid`. It appears within P cycles of a burst where all pipelines request together. A stuck or lost ID in the issue pipeline sends a reply to the wrong pipeline or loses it. The error is visible three cycles after capture, through the strobe and through the miss mask, which excludes the requester's own port. Table state is checked through later lookups. A wrong commit, update or eviction changes `rsp_hit` and `rsp_mask` on the next lookup of the affected address. A request slot that stays full holds `req_ready` low and `lrn_ready` low from the next cycle.

// File: rtl/lkp_pkg.sv
package lkp_pkg;

  // Kind of table write selected for a learning request.
  typedef enum logic [1:0] {
    WR_NONE,
    WR_UPDATE,
    WR_FILL,
    WR_EVICT
  } wr_kind_e;

endpackage

// File: rtl/lkp_req_slot.sv
// One-deep request holding register for a single pipeline.
module lkp_req_slot #(
  parameter int MAC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [MAC_W-1:0] push_mac,
  input  logic             grant,
  output logic             full,
  output logic [MAC_W-1:0] mac_q,
  output logic             overrun
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= 1'b0;
      mac_q   <= '0;
      overrun <= 1'b0;
    end else begin
      overrun <= push_valid & full;
      if (grant) begin
        full <= 1'b0;
      end else if (push_valid && !full) begin
        full  <= 1'b1;
        mac_q <= push_mac;
      end
    end
  end

endmodule

// File: rtl/lkp_rr_arb.sv
// Round-robin pick among pending slots, one grant per cycle.
module lkp_rr_arb #(
  parameter int N    = 4,
  localparam int ID_W = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  output logic            gnt_any,
  output logic [ID_W-1:0] gnt_id
);

  logic [ID_W-1:0] last;

  always_comb begin
    int idx;
    gnt_any = 1'b0;
    gnt_id  = last;
    for (int k = 1; k <= N; k++) begin
      idx = (int'(last) + k) % N;
      if (!gnt_any && req[idx]) begin
        gnt_any = 1'b1;
        gnt_id  = ID_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last <= ID_W'(N - 1);
    end else if (gnt_any) begin
      last <= gnt_id;
    end
  end

endmodule

// File: rtl/lkp_mac_table.sv
// Associative address table: combinational read, learning write with
// update, fill and rotating eviction.
module lkp_mac_table
  import lkp_pkg::*;
#(
  parameter int P     = 4,
  parameter int MAC_W = 48,
  parameter int DEPTH = 8,
  localparam int PW    = $clog2(P),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [MAC_W-1:0] rd_mac,
  output logic             rd_hit,
  output logic [PW-1:0]    rd_port,
  input  logic             wr_en,
  input  logic [MAC_W-1:0] wr_mac,
  input  logic [PW-1:0]    wr_port
);

  logic [DEPTH-1:0] ent_v;
  logic [MAC_W-1:0] ent_mac  [DEPTH];
  logic [PW-1:0]    ent_port [DEPTH];
  logic [IDX_W-1:0] victim;

  logic             m_hit, f_hit;
  logic [IDX_W-1:0] m_idx, f_idx, w_idx;
  wr_kind_e         kind;

  always_comb begin
    rd_hit  = 1'b0;
    rd_port = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!rd_hit && ent_v[k] && ent_mac[k] == rd_mac) begin
        rd_hit  = 1'b1;
        rd_port = ent_port[k];
      end
    end
  end

  always_comb begin
    m_hit = 1'b0;
    m_idx = '0;
    f_hit = 1'b0;
    f_idx = '0;
    for (int k = 0; k < DEPTH; k++) begin
      if (!m_hit && ent_v[k] && ent_mac[k] == wr_mac) begin
        m_hit = 1'b1;
        m_idx = IDX_W'(k);
      end
      if (!f_hit && !ent_v[k]) begin
        f_hit = 1'b1;
        f_idx = IDX_W'(k);
      end
    end
    if (!wr_en) begin
      kind  = WR_NONE;
      w_idx = '0;
    end else if (m_hit) begin
      kind  = WR_UPDATE;
      w_idx = m_idx;
    end else if (f_hit) begin
      kind  = WR_FILL;
      w_idx = f_idx;
    end else begin
      kind  = WR_EVICT;
      w_idx = victim;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_v  <= '0;
      victim <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        ent_mac[k]  <= '0;
        ent_port[k] <= '0;
      end
    end else if (kind != WR_NONE) begin
      ent_v[w_idx]    <= 1'b1;
      ent_mac[w_idx]  <= wr_mac;
      ent_port[w_idx] <= wr_port;
      if (kind == WR_EVICT) begin
        victim <= (int'(victim) == DEPTH - 1) ? '0 : victim + 1'b1;
      end
    end
  end

endmodule

// File: rtl/lkp_orchestrator.sv
// Shares one address table between P ingress pipelines.
module lkp_orchestrator #(
  parameter int P     = 4,
  parameter int MAC_W = 48,
  parameter int DEPTH = 8,
  localparam int ID_W = $clog2(P)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [P-1:0]       req_valid,
  output logic [P-1:0]       req_ready,
  input  logic [P*MAC_W-1:0] req_mac,
  output logic [P-1:0]       req_overrun,
  output logic [P-1:0]       rsp_valid,
  output logic               rsp_hit,
  output logic [P-1:0]       rsp_mask,
  input  logic               lrn_valid,
  output logic               lrn_ready,
  input  logic               lrn_fcs_ok,
  input  logic [MAC_W-1:0]   lrn_mac,
  input  logic [ID_W-1:0]    lrn_port
);

  localparam logic [P-1:0] ONE = P'(1);

  logic [P-1:0]     slot_full;
  logic [P-1:0]     grant_vec;
  logic [MAC_W-1:0] slot_mac [P];
  logic             gnt_any;
  logic [ID_W-1:0]  gnt_id;

  for (genvar g = 0; g < P; g++) begin : g_slot
    assign grant_vec[g] = gnt_any && (gnt_id == ID_W'(g));
    lkp_req_slot #(.MAC_W(MAC_W)) i_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .push_valid(req_valid[g]),
      .push_mac  (req_mac[g*MAC_W +: MAC_W]),
      .grant     (grant_vec[g]),
      .full      (slot_full[g]),
      .mac_q     (slot_mac[g]),
      .overrun   (req_overrun[g])
    );
  end

  assign req_ready = ~slot_full;

  lkp_rr_arb #(.N(P)) i_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .req    (slot_full),
    .gnt_any(gnt_any),
    .gnt_id (gnt_id)
  );

  // Issue stage: granted address plus requester ID.
  logic             s1_v;
  logic [ID_W-1:0]  s1_id;
  logic [MAC_W-1:0] s1_mac;
  // Reply stage.
  logic             s2_v;
  logic [ID_W-1:0]  s2_id;
  logic             s2_hit;
  logic [P-1:0]     s2_mask;

  logic            tbl_hit;
  logic [ID_W-1:0] tbl_port;
  logic            wr_en;

  assign lrn_ready = ~|slot_full;
  assign wr_en     = lrn_valid & lrn_ready & lrn_fcs_ok;

  lkp_mac_table #(.P(P), .MAC_W(MAC_W), .DEPTH(DEPTH)) i_tbl (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_mac (s1_mac),
    .rd_hit (tbl_hit),
    .rd_port(tbl_port),
    .wr_en  (wr_en),
    .wr_mac (lrn_mac),
    .wr_port(lrn_port)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_v    <= 1'b0;
      s1_id   <= '0;
      s1_mac  <= '0;
      s2_v    <= 1'b0;
      s2_id   <= '0;
      s2_hit  <= 1'b0;
      s2_mask <= '0;
    end else begin
      s1_v   <= gnt_any;
      s1_id  <= gnt_id;
      s1_mac <= slot_mac[gnt_id];
      s2_v   <= s1_v;
      s2_id  <= s1_id;
      s2_hit <= s1_v & tbl_hit;
      if (tbl_hit) begin
        s2_mask <= (ONE << tbl_port) & ~(ONE << s1_id);
      end else begin
        s2_mask <= ~(ONE << s1_id);
      end
    end
  end

  assign rsp_valid = s2_v ? (ONE << s2_id) : '0;
  assign rsp_hit   = s2_v & s2_hit;
  assign rsp_mask  = s2_v ? s2_mask : '0;

endmodule

// File: rtl/lkp_orchestrator_chk.sv
module lkp_orchestrator_chk #(
  parameter int P = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic [P-1:0] req_valid,
  input logic [P-1:0] req_ready,
  input logic [P-1:0] req_overrun,
  input logic [P-1:0] rsp_valid,
  input logic         rsp_hit,
  input logic [P-1:0] rsp_mask
);

  localparam logic [P-1:0] ONE = P'(1);

  assert_one_reply_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_valid));

  for (genvar i = 0; i < P; i++) begin : g_pipe
    logic [7:0] low_cnt;
    always_ff @(posedge clk) begin
      if (!rst_n) low_cnt <= '0;
      else if (!req_ready[i]) low_cnt <= low_cnt + 8'd1;
      else low_cnt <= '0;
    end

    assert_wait_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !req_ready[i] |-> int'(low_cnt) < P);

    assert_reply_follows_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(req_ready[i]) |=> rsp_valid[i]);

    assert_miss_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] && !rsp_hit |-> rsp_mask == ~(ONE << i));

    assert_hit_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[i] && rsp_hit |-> !rsp_mask[i] && $countones(rsp_mask) <= 1);

    assert_overrun_R11: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[i] && !req_ready[i] |=> req_overrun[i]);
  end

endmodule

bind lkp_orchestrator lkp_orchestrator_chk #(.P(P)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_overrun(req_overrun),
  .rsp_valid  (rsp_valid),
  .rsp_hit    (rsp_hit),
  .rsp_mask   (rsp_mask)
);

// File: tb/test_lkp_orchestrator.sv
module test_lkp_orchestrator;
  localparam int CLK_PERIOD = 10;
  localparam int P = 4;
  localparam int MAC_W = 48;
  localparam int DEPTH = 8;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [P-1:0]       req_valid = '0;
  logic [P-1:0]       req_ready;
  logic [P*MAC_W-1:0] req_mac = '0;
  logic [P-1:0]       req_overrun;
  logic [P-1:0]       rsp_valid;
  logic               rsp_hit;
  logic [P-1:0]       rsp_mask;
  logic               lrn_valid = 1'b0;
  logic               lrn_ready;
  logic               lrn_fcs_ok = 1'b0;
  logic [MAC_W-1:0]   lrn_mac = '0;
  logic [1:0]         lrn_port = '0;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lkp_orchestrator #(.P(P), .MAC_W(MAC_W), .DEPTH(DEPTH)) i_lkp_orchestrator (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_mac(req_mac),
    .req_overrun(req_overrun),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_mask(rsp_mask),
    .lrn_valid(lrn_valid), .lrn_ready(lrn_ready), .lrn_fcs_ok(lrn_fcs_ok),
    .lrn_mac(lrn_mac), .lrn_port(lrn_port)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_rsp(input string tag, input int pipe, input bit hit, input logic [P-1:0] mask);
    chk({tag, " rsp_valid"}, 64'(rsp_valid), 64'(4'b1 << pipe));
    chk({tag, " rsp_hit"}, 64'(rsp_hit), 64'(hit));
    chk({tag, " rsp_mask"}, 64'(rsp_mask), 64'(mask));
  endtask

  // Lookup from one pipeline, checking handshake and exact latency (R2, R3).
  task automatic do_lookup(input string tag, input int pipe, input logic [MAC_W-1:0] mac,
                           input bit hit, input logic [P-1:0] mask);
    @(negedge clk);
    chk({tag, " R2 ready before"}, 64'(req_ready[pipe]), 64'd1);
    req_valid[pipe] = 1'b1;
    req_mac[pipe*MAC_W +: MAC_W] = mac;
    @(negedge clk);
    req_valid[pipe] = 1'b0;
    chk({tag, " R2 ready low"}, 64'(req_ready[pipe]), 64'd0);
    @(negedge clk);
    chk({tag, " R2 ready back"}, 64'(req_ready[pipe]), 64'd1);
    chk({tag, " R3 no early reply"}, 64'(rsp_valid), 64'd0);
    @(negedge clk);
    chk_rsp(tag, pipe, hit, mask);
  endtask

  task automatic do_learn(input string tag, input logic [MAC_W-1:0] mac, input int port, input bit ok);
    @(negedge clk);
    chk({tag, " R8 lrn_ready idle"}, 64'(lrn_ready), 64'd1);
    lrn_valid = 1'b1;
    lrn_mac = mac;
    lrn_port = 2'(port);
    lrn_fcs_ok = ok;
    @(negedge clk);
    lrn_valid = 1'b0;
    lrn_fcs_ok = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 req_ready", 64'(req_ready), 64'hF);
    chk("R1 lrn_ready", 64'(lrn_ready), 64'd1);
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 req_overrun", 64'(req_overrun), 64'd0);
  endtask

  task automatic t_miss;
    do_lookup("R6 miss p0", 0, 48'hA0_0000_0001, 1'b0, 4'b1110);
    do_lookup("R6 miss p3", 3, 48'hA0_0000_0002, 1'b0, 4'b0111);
  endtask

  task automatic t_learn_hit;
    do_learn("R7 learn", 48'hB0_0000_0001, 2, 1'b1);
    do_lookup("R7 hit p0", 0, 48'hB0_0000_0001, 1'b1, 4'b0100);
    do_lookup("R7 hit own port p2", 2, 48'hB0_0000_0001, 1'b1, 4'b0000);
  endtask

  task automatic t_bad_fcs;
    do_learn("R9 learn bad", 48'hC0_0000_0001, 3, 1'b0);
    do_lookup("R9 still miss", 1, 48'hC0_0000_0001, 1'b0, 4'b1101);
  endtask

  task automatic t_update;
    do_learn("R10 relearn", 48'hB0_0000_0001, 3, 1'b1);
    do_lookup("R10 updated port", 0, 48'hB0_0000_0001, 1'b1, 4'b1000);
  endtask

  // All pipelines request together; replies follow round-robin order (R4, R5).
  task automatic t_rr(input string tag, input int first);
    @(negedge clk);
    req_valid = 4'hF;
    for (int i = 0; i < P; i++) req_mac[i*MAC_W +: MAC_W] = 48'hD0_0000_0000 + 48'(i);
    @(negedge clk);
    req_valid = '0;
    @(negedge clk);
    for (int k = 0; k < P; k++) begin
      int p;
      p = (first + k) % P;
      @(negedge clk);
      chk_rsp({tag, " R4 R5 order"}, p, 1'b0, ~(4'b1 << p));
    end
    @(negedge clk);
    chk({tag, " R4 ready all"}, 64'(req_ready), 64'hF);
  endtask

  task automatic t_learn_block;
    @(negedge clk);
    req_valid[1] = 1'b1;
    req_mac[1*MAC_W +: MAC_W] = 48'hE0_0000_0001;
    @(negedge clk);
    req_valid[1] = 1'b0;
    chk("R8 lrn_ready blocked", 64'(lrn_ready), 64'd0);
    @(negedge clk);
    chk("R8 lrn_ready free", 64'(lrn_ready), 64'd1);
    @(negedge clk);
    chk_rsp("R8 reply", 1, 1'b0, 4'b1101);
  endtask

  task automatic t_overrun;
    @(negedge clk);
    req_valid[2] = 1'b1;
    req_mac[2*MAC_W +: MAC_W] = 48'hF0_0000_0001;
    @(negedge clk);
    chk("R11 ready low", 64'(req_ready[2]), 64'd0);
    req_mac[2*MAC_W +: MAC_W] = 48'hB0_0000_0001;
    @(negedge clk);
    req_valid[2] = 1'b0;
    chk("R11 overrun pulse", 64'(req_overrun), 64'b0100);
    @(negedge clk);
    chk_rsp("R11 original kept", 2, 1'b0, 4'b1011);
    chk("R11 overrun clears", 64'(req_overrun), 64'd0);
    @(negedge clk);
    chk("R11 no second reply", 64'(rsp_valid), 64'd0);
  endtask

  // Table holds one entry; fill the rest, then one more evicts entry 0 (R12).
  task automatic t_evict;
    for (int k = 0; k < DEPTH - 1; k++) do_learn("R12 fill", 48'h90_0000_0000 + 48'(k), k % P, 1'b1);
    do_learn("R12 evict", 48'h9F_0000_0000, 1, 1'b1);
    do_lookup("R12 evicted miss", 0, 48'hB0_0000_0001, 1'b0, 4'b1110);
    do_lookup("R12 kept hit", 3, 48'h90_0000_0002, 1'b1, 4'b0100);
    do_lookup("R12 new hit", 2, 48'h9F_0000_0000, 1'b1, 4'b0010);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_miss();
    t_learn_hit();
    t_bad_fcs();
    t_update();
    do_lookup("R4 set pointer p3", 3, 48'hD1_0000_0000, 1'b0, 4'b0111);
    t_rr("rr from0", 0);
    do_lookup("R4 set pointer p1", 1, 48'hD1_0000_0001, 1'b0, 4'b1101);
    t_rr("rr from2", 2);
    t_learn_block();
    t_overrun();
    t_evict();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule